// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate Unit with Run-Time Operand Signedness

This block multiplies two operands and keeps a running sum of the products. Each operand has its own control bit that picks, cycle by cycle, whether the operand is a two's-complement signed number or an unsigned number. A load control starts the sum again from the product that arrives at the accumulator, with no add. A sticky overflow flag shows that the true running value no longer fits the result width under the signedness in force.

All stages run on one clock with a shared clock enable and an asynchronous clear. The A and B input registers, the sign-control registers, the load-control registers and the multiplier output register can each be kept or bypassed. Extra latency can be added after the multiplier and at the output. The register after the accumulator is always present. The registered operands come out on chain ports, so several units can be cascaded.

Top module: `mul_accum`

## Requirements
- R1: When both sign controls are low, the product is the unsigned product of A and B. For example, 0xFF times 0xFF gives 65025.
- R2: Each sign control acts only on its own operand. High means two's-complement signed and low means unsigned. For example, A=0xFF signed times B=200 unsigned gives -200, and 0xFF times 0xFF with both signed gives 1.
- R3: When load is low, the new result is the previous result plus the product, taken modulo 2^R_W.
- R4: When load is high, the result is replaced by the product, with no add.
- R5: The overflow flag is computed against the full-precision sum. If either sign control is high, the range is -2^(R_W-1) to 2^(R_W-1)-1. Otherwise the range is 0 to 2^R_W-1. Once set, the flag stays high until a load whose product fits.
- R6: An input pair appears at the result after A_REG+MUL_OREG+MUL_LAT+1+OUT_LAT enabled clock edges. The default is 6. The sign and load controls must reach the multiplier through the same number of registers as the operands.
- R7: While ce is low, no register changes, and result, ovf and the chain ports hold their values.
- R8: A high clr zeroes result, ovf, the accumulator and every pipeline stage at once, without waiting for a clock edge.
- R9: a_chain and b_chain carry the registered A and B. With the input register enabled, they show the operand captured at the last enabled edge.
- R10: Each operand and result width lies in 1..256. MUL_LAT and OUT_LAT each take a value from 0 to 8, or 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all stages |
| clr | input | 1 | Asynchronous clear, active high |
| ce | input | 1 | Clock enable for every stage |
| a | input | A_W | Operand A |
| b | input | B_W | Operand B |
| a_signed | input | 1 | 1: A is signed, 0: A is unsigned |
| b_signed | input | 1 | 1: B is signed, 0: B is unsigned |
| load | input | 1 | 1: restart the sum from the product |
| result | output | R_W | Accumulated value |
| ovf | output | 1 | Sticky overflow flag |
| a_chain | output | A_W | Registered A, for cascading |
| b_chain | output | B_W | Registered B, for cascading |

## Verification
The assertions assume that the sign and load controls pass through as many registers as the operands do. If they did not, the load and sticky-flag properties would judge a product against the wrong control. The stimulus relies on the default parameters, in which all three paths have one register. Every control value is applied in the same cycle as the operand pair it belongs to. The clear is released only away from a clock edge, so the hold and chain properties always start from a settled reset.

// File: rtl/mac_dly.sv
module mac_dly #(
  parameter int W = 8,
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  if (N == 0) begin : g_wire
    assign q = d;
  end else begin : g_regs
    logic [W-1:0] r [N];
    always_ff @(posedge clk or posedge clr) begin
      if (clr) begin
        for (int i = 0; i < N; i++) r[i] <= '0;
      end else if (ce) begin
        r[0] <= d;
        for (int i = 1; i < N; i++) r[i] <= r[i-1];
      end
    end
    assign q = r[N-1];
  end
endmodule

// File: rtl/mul_accum.sv
module mul_accum #(
  parameter int A_W         = 8,
  parameter int B_W         = 8,
  parameter int R_W         = 24,
  parameter bit A_REG       = 1,
  parameter bit B_REG       = 1,
  parameter bit SA_IN_REG   = 1,
  parameter bit SA_PIPE_REG = 0,
  parameter bit SB_IN_REG   = 1,
  parameter bit SB_PIPE_REG = 0,
  parameter bit LD_IN_REG   = 1,
  parameter bit LD_PIPE_REG = 0,
  parameter bit MUL_OREG    = 1,
  parameter int MUL_LAT     = 1,
  parameter int OUT_LAT     = 2
) (
  input  logic           clk,
  input  logic           clr,
  input  logic           ce,
  input  logic [A_W-1:0] a,
  input  logic [B_W-1:0] b,
  input  logic           a_signed,
  input  logic           b_signed,
  input  logic           load,
  output logic [R_W-1:0] result,
  output logic           ovf,
  output logic [A_W-1:0] a_chain,
  output logic [B_W-1:0] b_chain
);
  localparam int PW   = A_W + B_W + 2;
  localparam int SW   = ((R_W > PW) ? R_W : PW) + 2;
  localparam int SA_D = int'(SA_IN_REG) + int'(SA_PIPE_REG);
  localparam int SB_D = int'(SB_IN_REG) + int'(SB_PIPE_REG);
  localparam int LD_D = int'(LD_IN_REG) + int'(LD_PIPE_REG);
  localparam int MS   = int'(MUL_OREG) + MUL_LAT;
  localparam int MW   = PW + 2;

  function automatic bit lat_ok(input int v);
    return (v >= 0 && v <= 8) || v == 12;
  endfunction

  // R10
  initial legal_cfg_chk: assert (lat_ok(MUL_LAT) && lat_ok(OUT_LAT) &&
    A_W >= 1 && A_W <= 256 && B_W >= 1 && B_W <= 256 && R_W >= 1 && R_W <= 256)
    else $error("mul_accum: illegal width or latency parameter");

  logic [A_W-1:0] a_s;
  logic [B_W-1:0] b_s;
  logic           sa_s, sb_s, ld_s;

  mac_dly #(.W(A_W), .N(int'(A_REG))) u_areg (.clk(clk), .clr(clr), .ce(ce), .d(a), .q(a_s));
  mac_dly #(.W(B_W), .N(int'(B_REG))) u_breg (.clk(clk), .clr(clr), .ce(ce), .d(b), .q(b_s));
  mac_dly #(.W(1), .N(SA_D)) u_sareg (.clk(clk), .clr(clr), .ce(ce), .d(a_signed), .q(sa_s));
  mac_dly #(.W(1), .N(SB_D)) u_sbreg (.clk(clk), .clr(clr), .ce(ce), .d(b_signed), .q(sb_s));
  mac_dly #(.W(1), .N(LD_D)) u_ldreg (.clk(clk), .clr(clr), .ce(ce), .d(load), .q(ld_s));

  assign a_chain = a_s;
  assign b_chain = b_s;

  logic signed [A_W:0]  ax;
  logic signed [B_W:0]  bx;
  logic signed [PW-1:0] prod;
  assign ax   = {sa_s & a_s[A_W-1], a_s};
  assign bx   = {sb_s & b_s[B_W-1], b_s};
  assign prod = ax * bx;

  logic [MW-1:0] m_q;
  mac_dly #(.W(MW), .N(MS)) u_mpipe (
    .clk(clk), .clr(clr), .ce(ce),
    .d({ld_s, sa_s | sb_s, prod}), .q(m_q)
  );

  logic          ld_m, sg_m;
  logic [PW-1:0] pm;
  assign ld_m = m_q[MW-1];
  assign sg_m = m_q[MW-2];
  assign pm   = m_q[PW-1:0];

  logic [R_W-1:0] acc_q;
  logic           ovf_q;
  logic [SW-1:0]  pext, aext, sum;
  logic           fits;

  assign pext = {{(SW-PW){pm[PW-1]}}, pm};
  assign aext = {{(SW-R_W){sg_m & acc_q[R_W-1]}}, acc_q};
  assign sum  = ld_m ? pext : aext + pext;
  assign fits = sg_m ? ((&sum[SW-1:R_W-1]) | ~(|sum[SW-1:R_W-1]))
                     : ~(|sum[SW-1:R_W]);

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else if (ce) begin
      acc_q <= sum[R_W-1:0];
      ovf_q <= ~fits | (ovf_q & ~ld_m);
    end
  end

  mac_dly #(.W(R_W+1), .N(OUT_LAT)) u_opipe (
    .clk(clk), .clr(clr), .ce(ce),
    .d({ovf_q, acc_q}), .q({ovf, result})
  );

  // R1
  uns_prod_chk: assert property (@(posedge clk) disable iff (clr)
    (!sa_s && !sb_s) |-> !prod[PW-1]);

  // R2
  mixed_sign_chk: assert property (@(posedge clk) disable iff (clr)
    (sa_s && !sb_s && a_s[A_W-1] && (|b_s)) |-> prod[PW-1]);

  // R4
  load_chk: assert property (@(posedge clk) disable iff (clr)
    (ce && ld_m) |=> acc_q == $past(pext[R_W-1:0]));

  // R5
  sticky_ovf_chk: assert property (@(posedge clk) disable iff (clr)
    (ce && ovf_q && !ld_m) |=> ovf_q);

  // R7
  ce_hold_chk: assert property (@(posedge clk) disable iff (clr)
    !ce |=> ($stable(result) && $stable(ovf) && $stable(a_chain) && $stable(b_chain)));

  // R9
  if (A_REG) begin : g_chain_a_chk
    chain_a_chk: assert property (@(posedge clk) disable iff (clr)
      ce |=> a_chain == $past(a));
  end
endmodule

// File: tb/sim_mul_accum.sv
module sim_mul_accum;
  localparam int D = 6;

  logic        clk = 1'b0;
  logic        clr = 1'b1;
  logic        ce = 1'b0;
  logic [7:0]  a = '0, b = '0;
  logic        sa = 1'b0, sb = 1'b0, ld = 1'b0;
  logic [23:0] result;
  logic        ovf;
  logic [7:0]  a_chain, b_chain;

  mul_accum #(.A_W(8), .B_W(8), .R_W(24), .MUL_LAT(1), .OUT_LAT(2)) u0 (
    .clk(clk), .clr(clr), .ce(ce), .a(a), .b(b), .a_signed(sa), .b_signed(sb),
    .load(ld), .result(result), .ovf(ovf), .a_chain(a_chain), .b_chain(b_chain)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0, n = 0;
  bit done = 1'b0;
  logic [23:0] m_acc = '0;
  bit          m_ovf = 1'b0;
  logic [23:0] er [0:4095];
  bit          eo [0:4095];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    n = 0; m_acc = '0; m_ovf = 1'b0; er[0] = '0; eo[0] = 1'b0;
  endtask

  task automatic step(input logic [7:0] ia, input logic [7:0] ib, input bit isa,
                      input bit isb, input bit ild, input bit ice, input string tag);
    longint pa, pb, prod, accv, sum;
    bit sg, fit;
    int idx;
    @(negedge clk);
    a = ia; b = ib; sa = isa; sb = isb; ld = ild; ce = ice;
    @(posedge clk);
    if (ice) begin
      pa   = isa ? longint'($signed(ia)) : longint'(ia);
      pb   = isb ? longint'($signed(ib)) : longint'(ib);
      prod = pa * pb;
      sg   = isa | isb;
      accv = sg ? longint'($signed(m_acc)) : longint'(m_acc);
      sum  = ild ? prod : accv + prod;
      fit  = sg ? (sum >= -(longint'(1) << 23) && sum < (longint'(1) << 23))
                : (sum >= 0 && sum < (longint'(1) << 24));
      m_ovf = ild ? !fit : (m_ovf | !fit);
      m_acc = sum[23:0];
      n++;
      er[n] = m_acc;
      eo[n] = m_ovf;
    end
    #1;
    idx = n - D + 1;
    if (idx < 0) idx = 0;
    chk({tag, " result"}, 32'(result), 32'(er[idx]));
    chk({tag, " ovf"}, 32'(ovf), 32'(eo[idx]));
    if (ice) begin
      chk("R9 a_chain", 32'(a_chain), 32'(ia));
      chk("R9 b_chain", 32'(b_chain), 32'(ib));
    end
  endtask

  task automatic flush(input string tag);
    for (int i = 0; i < D; i++) step(8'd0, 8'd0, 1'b0, 1'b0, 1'b0, 1'b1, tag);
  endtask

  task automatic t_reset();
    clr = 1'b1; ce = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 reset result", 32'(result), 32'd0);
    chk("R8 reset ovf", 32'(ovf), 32'd0);
    chk("R8 reset chain", 32'(a_chain), 32'd0);
    #2 clr = 1'b0;
    model_reset();
  endtask

  task automatic t_unsigned();
    step(8'hFF, 8'hFF, 0, 0, 1, 1, "R1");
    step(8'd3, 8'd4, 0, 0, 0, 1, "R3");
    step(8'd200, 8'd100, 0, 0, 0, 1, "R3");
    flush("R6");
    chk("R1 value", 32'(result), 32'd85037);
  endtask

  task automatic t_signed();
    step(8'hFF, 8'd200, 1, 0, 1, 1, "R2");
    flush("R2");
    chk("R2 sa only", 32'(result), 32'(24'hFFFF38));
    step(8'd200, 8'hFF, 0, 1, 1, 1, "R2");
    flush("R2");
    chk("R2 sb only", 32'(result), 32'(24'hFFFF38));
    step(8'hFF, 8'hFF, 1, 1, 1, 1, "R2");
    step(8'h80, 8'd2, 1, 1, 0, 1, "R3");
    flush("R3");
    chk("R3 signed sum", 32'(result), 32'(24'hFFFF01));
  endtask

  task automatic t_load();
    step(8'd10, 8'd10, 0, 0, 1, 1, "R4");
    step(8'd10, 8'd10, 0, 0, 0, 1, "R3");
    step(8'd7, 8'd6, 0, 0, 1, 1, "R4");
    step(8'd1, 8'd1, 0, 0, 0, 1, "R3");
    flush("R4");
    chk("R4 restart", 32'(result), 32'd43);
  endtask

  task automatic t_latency();
    step(8'd9, 8'd9, 0, 0, 1, 1, "R6");
    for (int i = 1; i < D - 1; i++) begin
      step(8'd0, 8'd0, 0, 0, 0, 1, "R6");
      chk("R6 not yet", 32'(result == 24'd81), 32'd0);
    end
    step(8'd0, 8'd0, 0, 0, 0, 1, "R6");
    chk("R6 arrives", 32'(result), 32'd81);
  endtask

  task automatic t_ovf_unsigned();
    step(8'hFF, 8'hFF, 0, 0, 1, 1, "R5");
    for (int i = 0; i < 260; i++) step(8'hFF, 8'hFF, 0, 0, 0, 1, "R5");
    flush("R5");
    chk("R5 unsigned set", 32'(ovf), 32'd1);
    step(8'd1, 8'd1, 0, 0, 0, 1, "R5");
    flush("R5");
    chk("R5 sticky", 32'(ovf), 32'd1);
    step(8'd1, 8'd1, 0, 0, 1, 1, "R5");
    flush("R5");
    chk("R5 cleared by load", 32'(ovf), 32'd0);
  endtask

  task automatic t_ovf_signed();
    step(8'h80, 8'hFF, 1, 0, 1, 1, "R5");
    for (int i = 0; i < 260; i++) step(8'h80, 8'hFF, 1, 0, 0, 1, "R5");
    flush("R5");
    chk("R5 signed set", 32'(ovf), 32'd1);
  endtask

  task automatic t_enable();
    logic [23:0] held;
    step(8'd5, 8'd5, 0, 0, 1, 1, "R7");
    step(8'd5, 8'd5, 0, 0, 0, 1, "R7");
    held = result;
    for (int i = 0; i < 4; i++) begin
      step(8'd99, 8'd99, 1, 1, 1, 0, "R7");
      chk("R7 frozen", 32'(result), 32'(held));
      chk("R7 chain frozen", 32'(a_chain), 32'd5);
    end
    flush("R7");
    chk("R7 resumed", 32'(result), 32'd50);
  endtask

  task automatic t_async_clear();
    step(8'd50, 8'd50, 0, 0, 1, 1, "R8");
    flush("R8");
    @(negedge clk);
    #2 clr = 1'b1;
    #1;
    chk("R8 async result", 32'(result), 32'd0);
    chk("R8 async chain", 32'(a_chain), 32'd0);
    @(negedge clk);
    #2 clr = 1'b0;
    model_reset();
    step(8'd2, 8'd3, 0, 0, 0, 1, "R8");
    flush("R8");
    chk("R8 fresh start", 32'(result), 32'd6);
  endtask

  task automatic t_random();
    for (int i = 0; i < 300; i++)
      step(8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
           ($urandom % 9) == 0, ($urandom % 6) != 0, "R3");
    flush("R3");
  endtask

  initial begin
    t_reset();
    t_unsigned();
    t_signed();
    t_load();
    t_latency();
    t_ovf_unsigned();
    t_ovf_signed();
    t_reset();
    t_enable();
    t_async_clear();
    t_random();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1500000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule